// File: doc/BRIEF.md
# Privilege-Aware Interrupt Pending Selector

This block decides, from a hart's interrupt state, whether a local interrupt should be taken right now and which cause number wins. It first keeps only the interrupts that are both pending and individually enabled. It then sorts each survivor into one of three groups using two delegation masks: interrupts kept at machine level, interrupts handed to the hypervisor-level supervisor, and interrupts handed further down to the virtual supervisor. Each group has its own global gate, which depends on the current privilege level, the machine and supervisor global enable bits, and whether virtualization is active.

Of the interrupts that pass their gate, the one with the lowest index wins. The block has no state and no clock. Its outputs follow its inputs within the same cycle, so trap-entry logic can sample them directly.

Top module: `irq_pend_sel`

## Requirements
- R1: An interrupt is a candidate only when its bit is set in both `pend_i` and `en_i`; a bit that is pending but not enabled is never taken.
- R2: Privilege is encoded U=0, S=1, M=3, and the value 2 is treated numerically. The machine enable is true when `priv_i` < 3, or when `priv_i` == 3 and `mie_i` is 1.
- R3: The supervisor enable is true when `priv_i` < 1, or when `priv_i` == 1 and `sie_i` is 1. It is false when `priv_i` is 2 or 3.
- R4: A candidate whose `mdeleg_i` bit is 0 survives exactly when the machine enable is true.
- R5: A candidate whose `mdeleg_i` bit is 1 and `hdeleg_i` bit is 0 survives exactly when `virt_i` is 1 or the supervisor enable is true.
- R6: A candidate whose `mdeleg_i` and `hdeleg_i` bits are both 1 survives exactly when `virt_i` is 1 and the supervisor enable is true.
- R7: When at least one candidate survives, `take_o` is 1 and `cause_o` is the lowest surviving bit index, from 0 to NUM_IRQ-1.
- R8: When no candidate survives, `take_o` is 0 and `cause_o` is 0.
- R9: The outputs are combinational. A change on any input shows on the outputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pend_i | input | NUM_IRQ | Pending interrupt bits |
| en_i | input | NUM_IRQ | Per-interrupt enable bits |
| mdeleg_i | input | NUM_IRQ | Machine-to-supervisor delegation mask |
| hdeleg_i | input | NUM_IRQ | Hypervisor-to-virtual-supervisor delegation mask |
| priv_i | input | 2 | Current privilege level (0=U, 1=S, 3=M) |
| mie_i | input | 1 | Machine global interrupt enable |
| sie_i | input | 1 | Supervisor global interrupt enable |
| virt_i | input | 1 | Virtualization active |
| take_o | output | 1 | An interrupt should be taken |
| cause_o | output | $clog2(NUM_IRQ) | Index of the winning interrupt, 0 when none |

## Verification
The bench drives interrupts that sit in the gated-off group and have a lower index than an interrupt in an open group. A selector that picked priority before gating would report the gated-off bit. It sets the supervisor enable bit while the hart is in machine mode, and uses privilege value 2; a design that compared privilege for equality instead of order would open or close the wrong groups there. It flips `virt_i` with the supervisor enable held constant, which separates the OR gate of the hypervisor group from the AND gate of the virtual group. It also places survivors at indices 0 and 63 and across encoder group boundaries, where an off-by-one in the two-level encoder would give a wrong cause.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef struct packed {
    logic m_en;
    logic hs_en;
    logic vs_en;
  } grp_en_t;
endpackage

// File: rtl/irq_priv_gate.sv
module irq_priv_gate
  import irq_sel_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       mie_i,
  input  logic       sie_i,
  input  logic       virt_i,
  output grp_en_t    gate_o
);
  logic m_glb, s_glb;

  always_comb begin
    m_glb = (priv_i < PRIV_M) || ((priv_i == PRIV_M) && mie_i);
    s_glb = (priv_i < PRIV_S) || ((priv_i == PRIV_S) && sie_i);
    gate_o.m_en  = m_glb;
    gate_o.hs_en = virt_i | s_glb;
    gate_o.vs_en = virt_i & s_glb;
  end

  always_comb begin
    AST_M_MODE_CLOSED: assert (!((priv_i == PRIV_M) && !mie_i && gate_o.m_en))
      else $error("machine gate open in M with mie clear"); // R2
    AST_VS_WITHIN_HS: assert (!gate_o.vs_en || gate_o.hs_en)
      else $error("vs gate open while hs gate closed"); // R6
    AST_HOST_S_CLOSED: assert (!((priv_i >= 2'd2) && !virt_i && gate_o.hs_en))
      else $error("hs gate open above S without virt"); // R3
  end
endmodule

// File: rtl/irq_deleg_mask.sv
module irq_deleg_mask
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] mdeleg_i,
  input  logic [NUM_IRQ-1:0] hdeleg_i,
  input  grp_en_t            gate_i,
  output logic [NUM_IRQ-1:0] surv_o
);
  logic [NUM_IRQ-1:0] cand, m_grp, hs_grp, vs_grp;

  always_comb begin
    cand   = pend_i & en_i;
    m_grp  = cand & ~mdeleg_i;
    hs_grp = cand &  mdeleg_i & ~hdeleg_i;
    vs_grp = cand &  mdeleg_i &  hdeleg_i;
    surv_o = (m_grp  & {NUM_IRQ{gate_i.m_en}})
           | (hs_grp & {NUM_IRQ{gate_i.hs_en}})
           | (vs_grp & {NUM_IRQ{gate_i.vs_en}});
  end

  always_comb begin
    AST_SURV_IN_CAND: assert ((surv_o & ~(pend_i & en_i)) == '0)
      else $error("survivor outside pending and enabled"); // R1
    AST_M_GRP_GATED: assert (gate_i.m_en || ((surv_o & ~mdeleg_i) == '0))
      else $error("machine group survived with gate closed"); // R4
  end
endmodule

// File: rtl/irq_low_pick.sv
module irq_low_pick #(
  parameter int NUM_IRQ = 64,
  parameter int GRP_W   = 8,
  localparam int IDX_W   = $clog2(NUM_IRQ),
  localparam int LOC_W   = $clog2(GRP_W),
  localparam int NUM_GRP = NUM_IRQ / GRP_W
) (
  input  logic [NUM_IRQ-1:0] vec_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_GRP-1:0]       grp_any;
  logic [NUM_GRP*LOC_W-1:0] grp_lo;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [GRP_W-1:0] slice;
    logic [LOC_W-1:0] lo;
    assign slice = vec_i[g*GRP_W +: GRP_W];
    always_comb begin
      lo = '0;
      for (int b = GRP_W - 1; b >= 0; b--) begin
        if (slice[b]) lo = LOC_W'(b);
      end
    end
    assign grp_any[g]               = |slice;
    assign grp_lo[g*LOC_W +: LOC_W] = lo;
  end

  always_comb begin
    idx_o = '0;
    for (int g = NUM_GRP - 1; g >= 0; g--) begin
      if (grp_any[g]) idx_o = IDX_W'(g * GRP_W) + IDX_W'(grp_lo[g*LOC_W +: LOC_W]);
    end
    any_o = |grp_any;
  end
endmodule

// File: rtl/irq_pend_sel.sv
module irq_pend_sel
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int GRP_W   = 8,
  localparam int IDX_W  = $clog2(NUM_IRQ)
) (
  input  logic [NUM_IRQ-1:0] pend_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] mdeleg_i,
  input  logic [NUM_IRQ-1:0] hdeleg_i,
  input  logic [1:0]         priv_i,
  input  logic               mie_i,
  input  logic               sie_i,
  input  logic               virt_i,
  output logic               take_o,
  output logic [IDX_W-1:0]   cause_o
);
  grp_en_t            gate;
  logic [NUM_IRQ-1:0] surv;

  irq_priv_gate u_gate (
    .priv_i (priv_i),
    .mie_i  (mie_i),
    .sie_i  (sie_i),
    .virt_i (virt_i),
    .gate_o (gate)
  );

  irq_deleg_mask #(.NUM_IRQ(NUM_IRQ)) u_mask (
    .pend_i   (pend_i),
    .en_i     (en_i),
    .mdeleg_i (mdeleg_i),
    .hdeleg_i (hdeleg_i),
    .gate_i   (gate),
    .surv_o   (surv)
  );

  irq_low_pick #(.NUM_IRQ(NUM_IRQ), .GRP_W(GRP_W)) u_pick (
    .vec_i (surv),
    .any_o (take_o),
    .idx_o (cause_o)
  );

  always_comb begin
    AST_TAKE_IFF_SURV: assert (take_o == (surv != '0))
      else $error("take flag disagrees with survivors"); // R7
    AST_CAUSE_SET: assert (!take_o || surv[cause_o])
      else $error("cause points at a non-survivor"); // R7
    AST_NONE_BELOW: assert (!take_o || ((surv & ((NUM_IRQ'(1) << cause_o) - NUM_IRQ'(1))) == '0))
      else $error("lower survivor skipped"); // R7
    AST_IDLE_ZERO: assert (take_o || (cause_o == '0))
      else $error("cause nonzero with nothing taken"); // R8
  end
endmodule

// File: tb/sim_irq_pend_sel.sv
module sim_irq_pend_sel;
  localparam int N = 64;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0] pend, en, md, hd;
  logic [1:0]   priv;
  logic         mie, sie, virt;
  logic         take;
  logic [5:0]   cause;
  int checks = 0, errors = 0;
  bit done = 0;

  irq_pend_sel u0 (
    .pend_i(pend), .en_i(en), .mdeleg_i(md), .hdeleg_i(hd),
    .priv_i(priv), .mie_i(mie), .sie_i(sie), .virt_i(virt),
    .take_o(take), .cause_o(cause)
  );

  task automatic ref_model(output bit et, output int ec);
    bit men, sen, ok;
    men = (priv < 3) || (priv == 3 && mie);
    sen = (priv < 1) || (priv == 1 && sie);
    et = 0; ec = 0;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && en[i]) begin
        if (!md[i])      ok = men;
        else if (!hd[i]) ok = virt || sen;
        else             ok = virt && sen;
        if (ok && !et) begin et = 1; ec = i; end
      end
    end
  endtask

  task automatic check(input string tag);
    bit et; int ec;
    ref_model(et, ec);
    checks++;
    if (take !== et || int'(cause) != ec) begin
      errors++;
      $display("FAIL %s take=%0b cause=%0d expected take=%0b cause=%0d", tag, take, cause, et, ec);
    end
  endtask

  task automatic expect_out(input string tag, input bit et, input int ec);
    checks++;
    if (take !== et || int'(cause) != ec) begin
      errors++;
      $display("FAIL %s take=%0b cause=%0d expected take=%0b cause=%0d", tag, take, cause, et, ec);
    end
  endtask

  task automatic apply(input logic [N-1:0] p, input logic [N-1:0] e,
                       input logic [N-1:0] m, input logic [N-1:0] h,
                       input logic [1:0] pr, input bit mi, input bit si, input bit vi);
    @(posedge clk); #1;
    pend = p; en = e; md = m; hd = h; priv = pr; mie = mi; sie = si; virt = vi;
    @(negedge clk);
  endtask

  localparam logic [N-1:0] B3 = 64'h8, B9 = 64'h200, B10 = 64'h400;

  initial begin
    pend = '0; en = '0; md = '0; hd = '0; priv = 2'd3; mie = 0; sie = 0; virt = 0;
    @(negedge clk);
    expect_out("R8 reset", 0, 0);

    apply(64'h20, 64'h0, '0, '0, 2'd0, 0, 0, 0);
    expect_out("R1 pending not enabled", 0, 0);
    apply(B3, B3, '0, '0, 2'd3, 0, 0, 0);
    expect_out("R2 M mie0", 0, 0);
    apply(B3, B3, '0, '0, 2'd3, 1, 0, 0);
    expect_out("R2 M mie1", 1, 3);
    apply(B3, B3, '0, '0, 2'd1, 0, 0, 0);
    expect_out("R2 below M", 1, 3);
    apply(B3, B3, '0, '0, 2'd2, 0, 0, 0);
    expect_out("R2 priv2 below M", 1, 3);
    apply(B9, B9, B9, '0, 2'd1, 0, 0, 0);
    expect_out("R3 S sie0", 0, 0);
    apply(B9, B9, B9, '0, 2'd1, 0, 1, 0);
    expect_out("R3 S sie1", 1, 9);
    apply(B9, B9, B9, '0, 2'd0, 0, 0, 0);
    expect_out("R3 U below S", 1, 9);
    apply(B9, B9, B9, '0, 2'd3, 1, 1, 0);
    expect_out("R3 M ignores sie", 0, 0);
    apply(B9, B9, B9, '0, 2'd2, 1, 1, 0);
    expect_out("R3 priv2 closes S", 0, 0);
    apply(B9, B9, B9, '0, 2'd3, 0, 0, 1);
    expect_out("R5 virt opens hs", 1, 9);
    apply(B10, B10, B10, B10, 2'd1, 0, 1, 1);
    expect_out("R6 virt and sen", 1, 10);
    apply(B10, B10, B10, B10, 2'd1, 0, 1, 0);
    expect_out("R6 no virt", 0, 0);
    apply(B10, B10, B10, B10, 2'd1, 0, 0, 1);
    expect_out("R6 sie0", 0, 0);
    apply(B10, B10, B10, B10, 2'd0, 0, 0, 1);
    expect_out("R6 U virt", 1, 10);
    apply(B3 | 64'h20, B3 | 64'h20, 64'h20, '0, 2'd3, 0, 0, 1);
    expect_out("R4 gated low bit skipped", 1, 5);
    apply({1'b1, 62'd0, 1'b1}, '1, '0, '0, 2'd0, 0, 0, 0);
    expect_out("R7 bit0 over 63", 1, 0);
    apply({1'b1, 63'd0}, '1, '0, '0, 2'd0, 0, 0, 0);
    expect_out("R7 bit63", 1, 63);
    apply((64'h1 << 40) | (64'h1 << 17), '1, '0, '0, 2'd0, 0, 0, 0);
    expect_out("R7 bits 17 40", 1, 17);
    apply((64'h1 << 8) | (64'h1 << 7), '1, 64'h80, 64'h80, 2'd0, 0, 0, 0);
    expect_out("R7 group edge", 1, 8);

    // R9: change input mid-cycle, observe before any further edge
    #1 pend = 64'h1 << 33;
    #1 expect_out("R9 same cycle", 1, 33);
    #1 en = '0;
    #1 expect_out("R9 same cycle clear", 0, 0);

    for (int k = 0; k < 3000; k++) begin
      apply({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom},
            {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom},
            2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      check("R7 random");
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule